// File: doc/BRIEF.md
# Flash write-cycle protection front end

This block stands between the parallel control strobes of a NOR-style flash array and its internal command state machine. It decides which bus writes reach the command logic. Each active-low strobe (chip select, write strobe, read/output strobe) passes through a minimum-width filter counted in sample clocks. The filtered strobes then pass through a logical inhibit and a write-cycle tracker. At the end of a qualified cycle, the block emits a one-cycle command pulse. The pulse carries the address taken when the cycle opened and the data present when it closed.

A digital low-supply flag, which comes from an external comparator, locks the block out. While it is set, no command gets through and the command logic is held in its reset (array-read) state. Commands are accepted only after the write strobe has been seen inactive once since power-up or since the last lockout. A strobe held low through either event is therefore never taken as a command. A separate high-voltage-reset input enables temporary sector unprotect. While it is active, the effective per-sector protect vector reads all zeros. When it drops, the effective vector follows the stored protect vector again.

Top module: `flash_wr_guard`

## Requirements
- R1: While `rst` is high: `hold_cmd` is 1, `cmd_strobe` is 0, `unprot_active` is 0, `cmd_addr` and `cmd_data` are 0. Every filtered strobe is taken as asserted (low).
- R2: A write cycle opens only while the filtered `cs_n` is 0, the filtered `wr_n` is 0 and the filtered `rd_n` is 1. It closes when `cs_n` or `wr_n` goes back high. On close, `cmd_strobe` is 1 for exactly one cycle.
- R3: A filtered strobe takes a new level at the clock edge where that level has been sampled on GLITCH_CYC consecutive edges. A pulse of GLITCH_CYC samples is accepted. Any shorter pulse, low or high, has no effect.
- R4: If the filtered `rd_n` is 0 while a cycle is open, the cycle is dropped and no `cmd_strobe` is produced.
- R5: At every edge where `low_supply` is 1: any open cycle is dropped, `cmd_strobe` is 0 after that edge, and `hold_cmd` is 1 after that edge.
- R6: After reset, no cycle can open until the filtered `wr_n` has been seen at 1.
- R7: After `low_supply` returns to 0, no cycle can open until the filtered `wr_n` has been seen at 1 again.
- R8: `cmd_addr` is the `addr` value sampled at the edge where the cycle opens. `cmd_data` is the `wdata` value sampled at the edge where it closes. Neither changes at any edge that does not raise `cmd_strobe`.
- R9: `unprot_active` equals the previous cycle's (`hv_reset` AND NOT `low_supply`). While it is 1, `eff_prot` is all zeros. Otherwise `eff_prot` equals `sect_prot`.
- R10: `hold_cmd` equals the previous cycle's `low_supply` once out of reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high power-up reset |
| cs_n | input | 1 | Raw chip-select strobe, active low |
| wr_n | input | 1 | Raw write strobe, active low |
| rd_n | input | 1 | Raw output/read strobe, active low |
| addr | input | ADDR_W | Bus address |
| wdata | input | DATA_W | Bus write data |
| low_supply | input | 1 | Supply below lockout threshold |
| hv_reset | input | 1 | Reset pin at high-voltage level |
| sect_prot | input | NSECT | Stored per-sector protect bits |
| cmd_strobe | output | 1 | One-cycle accepted-command pulse |
| cmd_addr | output | ADDR_W | Address of accepted command |
| cmd_data | output | DATA_W | Data of accepted command |
| hold_cmd | output | 1 | Holds command logic in array-read reset and disables program/erase |
| unprot_active | output | 1 | Temporary unprotect in force |
| eff_prot | output | NSECT | Effective per-sector protect bits |

## Verification
Write cycles are driven four ways, and together these separate the strobe-ordering paths from the filter. The block is given write-strobe-controlled and chip-select-controlled cycles. It is given pulses one and two samples short of the threshold and pulses exactly at it. It also sees high glitches inside an open cycle, which must not split the cycle. Cycles are also spoiled by a low read strobe before opening and during an open cycle, which tells the inhibit apart from the abort. Supply lockout is applied mid-cycle and released with the write strobe still low, which shows the re-arm rule separately from power-up arming. The protect vector is changed under and outside temporary unprotect.

// File: rtl/flwg_pkg.sv
package flwg_pkg;

    // filtered view of the three active-low strobes
    typedef struct packed {
        logic rd_n;
        logic wr_n;
        logic cs_n;
    } strobe_t;

    localparam int NUM_STB = 3;

    typedef enum logic [0:0] {
        Q_IDLE  = 1'b0,
        Q_CYCLE = 1'b1
    } qual_state_e;

    // true when the strobes describe an active write
    function automatic logic wr_active(strobe_t s);
        return !s.cs_n && !s.wr_n && s.rd_n;
    endfunction

    // counter width for a filter of the given sample length
    function automatic int cnt_width(int len);
        return (len > 1) ? $clog2(len) : 1;
    endfunction

endpackage

// File: rtl/flwg_deglitch.sv
module flwg_deglitch #(
    parameter int GLITCH_CYC = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic raw,
    output logic filt
);
    import flwg_pkg::*;

    localparam int CW = cnt_width(GLITCH_CYC);
    localparam logic [CW-1:0] LAST = CW'(GLITCH_CYC - 1);

    logic [CW-1:0] run_q;
    logic          lvl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q <= 1'b0;          // assume asserted until proven otherwise
            run_q <= '0;
        end else if (raw == lvl_q) begin
            run_q <= '0;
        end else if (run_q == LAST) begin
            lvl_q <= raw;
            run_q <= '0;
        end else begin
            run_q <= run_q + 1'b1;
        end
    end

    assign filt = lvl_q;
endmodule

// File: rtl/flwg_qualify.sv
module flwg_qualify #(
    parameter int ADDR_W = 18,
    parameter int DATA_W = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  lockout,
    input  flwg_pkg::strobe_t     stb,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [DATA_W-1:0]     wdata,
    output logic                  cmd_strobe,
    output logic [ADDR_W-1:0]     cmd_addr,
    output logic [DATA_W-1:0]     cmd_data
);
    import flwg_pkg::*;

    qual_state_e       st_q;
    logic              armed_q;
    logic              pulse_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;
    logic              active;

    assign active = wr_active(stb);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= Q_IDLE;
            armed_q <= 1'b0;
            pulse_q <= 1'b0;
            addr_q  <= '0;
            data_q  <= '0;
        end else begin
            pulse_q <= 1'b0;
            if (lockout) begin
                st_q    <= Q_IDLE;
                armed_q <= 1'b0;
            end else begin
                if (!armed_q && stb.wr_n) begin
                    armed_q <= 1'b1;
                end
                unique case (st_q)
                    Q_IDLE: begin
                        if (armed_q && active) begin
                            st_q   <= Q_CYCLE;
                            addr_q <= addr;
                        end
                    end
                    Q_CYCLE: begin
                        if (!stb.rd_n) begin
                            st_q <= Q_IDLE;        // inhibit mid-cycle: drop
                        end else if (!active) begin
                            st_q    <= Q_IDLE;
                            pulse_q <= 1'b1;
                            data_q  <= wdata;
                        end
                    end
                    default: st_q <= Q_IDLE;
                endcase
            end
        end
    end

    assign cmd_strobe = pulse_q;
    assign cmd_addr   = addr_q;
    assign cmd_data   = data_q;
endmodule

// File: rtl/flwg_guard.sv
module flwg_guard #(
    parameter int NSECT = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             low_supply,
    input  logic             hv_reset,
    input  logic [NSECT-1:0] sect_prot,
    output logic             hold_cmd,
    output logic             unprot_active,
    output logic [NSECT-1:0] eff_prot
);
    logic hold_q;
    logic unprot_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q   <= 1'b1;
            unprot_q <= 1'b0;
        end else begin
            hold_q   <= low_supply;
            unprot_q <= hv_reset && !low_supply;
        end
    end

    assign hold_cmd      = hold_q;
    assign unprot_active = unprot_q;
    assign eff_prot      = unprot_q ? '0 : sect_prot;
endmodule

// File: rtl/flash_wr_guard.sv
module flash_wr_guard #(
    parameter int GLITCH_CYC = 3,
    parameter int ADDR_W     = 18,
    parameter int DATA_W     = 16,
    parameter int NSECT      = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              wr_n,
    input  logic              rd_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              low_supply,
    input  logic              hv_reset,
    input  logic [NSECT-1:0]  sect_prot,
    output logic              cmd_strobe,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [DATA_W-1:0] cmd_data,
    output logic              hold_cmd,
    output logic              unprot_active,
    output logic [NSECT-1:0]  eff_prot
);
    import flwg_pkg::*;

    strobe_t raw_s;
    strobe_t filt_s;
    logic [NUM_STB-1:0] raw_v;
    logic [NUM_STB-1:0] filt_v;

    assign raw_s = '{rd_n: rd_n, wr_n: wr_n, cs_n: cs_n};
    assign raw_v = raw_s;

    for (genvar i = 0; i < NUM_STB; i++) begin : g_flt
        flwg_deglitch #(.GLITCH_CYC(GLITCH_CYC)) u_flt (
            .clk  (clk),
            .rst  (rst),
            .raw  (raw_v[i]),
            .filt (filt_v[i])
        );
    end

    assign filt_s = filt_v;

    flwg_qualify #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_qual (
        .clk        (clk),
        .rst        (rst),
        .lockout    (low_supply),
        .stb        (filt_s),
        .addr       (addr),
        .wdata      (wdata),
        .cmd_strobe (cmd_strobe),
        .cmd_addr   (cmd_addr),
        .cmd_data   (cmd_data)
    );

    flwg_guard #(.NSECT(NSECT)) u_guard (
        .clk           (clk),
        .rst           (rst),
        .low_supply    (low_supply),
        .hv_reset      (hv_reset),
        .sect_prot     (sect_prot),
        .hold_cmd      (hold_cmd),
        .unprot_active (unprot_active),
        .eff_prot      (eff_prot)
    );
endmodule

// File: rtl/flwg_checker.sv
module flwg_checker #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              low_supply,
    input logic              hv_reset,
    input logic              cmd_strobe,
    input logic [DATA_W-1:0] cmd_data,
    input logic              hold_cmd,
    input logic              unprot_active
);
    p_single_pulse_r2: assert property (@(posedge clk) disable iff (rst)
        cmd_strobe |=> !cmd_strobe);

    p_lock_blocks_r5: assert property (@(posedge clk) disable iff (rst)
        low_supply |=> (hold_cmd && !cmd_strobe));

    p_lock_release_r10: assert property (@(posedge clk) disable iff (rst)
        !low_supply |=> !hold_cmd);

    p_data_held_r8: assert property (@(posedge clk) disable iff (rst)
        !cmd_strobe |-> $stable(cmd_data));

    p_unprot_enter_r9: assert property (@(posedge clk) disable iff (rst)
        (hv_reset && !low_supply) |=> unprot_active);

    p_unprot_leave_r9: assert property (@(posedge clk) disable iff (rst)
        (!hv_reset || low_supply) |=> !unprot_active);
endmodule

bind flash_wr_guard flwg_checker #(.DATA_W(DATA_W)) u_flwg_chk (
    .clk           (clk),
    .rst           (rst),
    .low_supply    (low_supply),
    .hv_reset      (hv_reset),
    .cmd_strobe    (cmd_strobe),
    .cmd_data      (cmd_data),
    .hold_cmd      (hold_cmd),
    .unprot_active (unprot_active)
);

// File: tb/tb_flash_wr_guard.sv
module tb_flash_wr_guard;
    localparam int GW = 3;
    localparam int AW = 18;
    localparam int DW = 16;
    localparam int NS = 11;

    logic clk = 1'b0;
    logic rst;
    logic cs_n, wr_n, rd_n;
    logic [AW-1:0] addr;
    logic [DW-1:0] wdata;
    logic low_supply, hv_reset;
    logic [NS-1:0] sect_prot;
    logic cmd_strobe, hold_cmd, unprot_active;
    logic [AW-1:0] cmd_addr;
    logic [DW-1:0] cmd_data;
    logic [NS-1:0] eff_prot;

    always #10 clk = ~clk;   // 50 MHz

    flash_wr_guard #(.GLITCH_CYC(GW), .ADDR_W(AW), .DATA_W(DW), .NSECT(NS)) dut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n),
        .addr(addr), .wdata(wdata), .low_supply(low_supply), .hv_reset(hv_reset),
        .sect_prot(sect_prot), .cmd_strobe(cmd_strobe), .cmd_addr(cmd_addr),
        .cmd_data(cmd_data), .hold_cmd(hold_cmd), .unprot_active(unprot_active),
        .eff_prot(eff_prot)
    );

    int checks = 0;
    int fails  = 0;
    int strobes = 0;
    bit done = 0;

    // ---------------- behavioural reference model ----------------
    int  m_lvl [3];    // 0 cs, 1 wr, 2 rd
    int  m_run [3];
    bit  m_armed, m_open, m_pulse, m_hold, m_unp;
    logic [AW-1:0] m_addr;
    logic [DW-1:0] m_data;

    always @(posedge clk) begin
        int raw [3];
        bit act;
        raw[0] = cs_n; raw[1] = wr_n; raw[2] = rd_n;
        if (rst) begin
            foreach (m_lvl[k]) begin m_lvl[k] = 0; m_run[k] = 0; end
            m_armed = 0; m_open = 0; m_pulse = 0; m_hold = 1; m_unp = 0;
            m_addr = '0; m_data = '0;
        end else begin
            act = (m_lvl[0] == 0) && (m_lvl[1] == 0) && (m_lvl[2] == 1);
            m_pulse = 0;
            if (low_supply) begin
                m_open = 0; m_armed = 0;
            end else begin
                bit was_armed;
                was_armed = m_armed;
                if (m_lvl[1] == 1) m_armed = 1;
                if (!m_open) begin
                    if (was_armed && act) begin m_open = 1; m_addr = addr; end
                end else if (m_lvl[2] == 0) begin
                    m_open = 0;
                end else if (!act) begin
                    m_open = 0; m_pulse = 1; m_data = wdata;
                end
            end
            m_hold = low_supply;
            m_unp  = hv_reset && !low_supply;
            for (int k = 0; k < 3; k++) begin
                if (raw[k] == m_lvl[k]) m_run[k] = 0;
                else if (m_run[k] == GW - 1) begin m_lvl[k] = raw[k]; m_run[k] = 0; end
                else m_run[k] = m_run[k] + 1;
            end
        end
    end

    task automatic note(bit ok, string req, string what, longint act_v, longint exp_v);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act_v, exp_v, $time);
        end
    endtask

    // per-clock comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (!done) begin
            if (cmd_strobe) strobes++;
            note(cmd_strobe == m_pulse, "R2", "cmd_strobe", cmd_strobe, m_pulse);
            note(cmd_addr == m_addr, "R8", "cmd_addr", cmd_addr, m_addr);
            note(cmd_data == m_data, "R8", "cmd_data", cmd_data, m_data);
            note(hold_cmd == m_hold, "R5", "hold_cmd", hold_cmd, m_hold);
            note(unprot_active == m_unp, "R9", "unprot_active", unprot_active, m_unp);
            note(eff_prot == (m_unp ? '0 : sect_prot), "R9", "eff_prot",
                 eff_prot, m_unp ? 0 : sect_prot);
        end
    end

    task automatic tick(int n);
        repeat (n) begin @(posedge clk); #2; end
    endtask

    task automatic expect_strobes(int n, string req);
        note(strobes == n, req, "strobe count", strobes, n);
        strobes = 0;
    endtask

    // write-strobe controlled write; data may change mid-pulse
    task automatic wr_cycle(logic [AW-1:0] a, logic [DW-1:0] d0, logic [DW-1:0] d1, int len);
        addr = a; wdata = d0; wr_n = 1'b0;
        tick(len);
        wdata = d1;
        tick(1);
        wr_n = 1'b1;
        tick(8);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        rst = 1; cs_n = 0; wr_n = 0; rd_n = 1; addr = '0; wdata = '0;
        low_supply = 0; hv_reset = 0; sect_prot = 11'h5A5;
        tick(5);
        @(negedge clk);
        note(hold_cmd && !cmd_strobe && !unprot_active && cmd_addr == '0 && cmd_data == '0,
             "R1", "reset outputs", {hold_cmd, cmd_strobe, unprot_active}, 3'b100);
        @(posedge clk); #2;
        rst = 0;
        strobes = 0;
        tick(15);
        expect_strobes(0, "R6");                 // strobe held active from power-up
        note(hold_cmd == 0, "R10", "hold after reset", hold_cmd, 0);

        wr_n = 1; tick(6);
        expect_strobes(0, "R6");

        // threshold width pulse, data changes inside pulse
        wr_cycle(18'h2AAA, 16'h1111, 16'h00AA, GW - 1);
        expect_strobes(1, "R3");
        note(cmd_addr == 18'h2AAA, "R8", "address from open", cmd_addr, 18'h2AAA);
        note(cmd_data == 16'h00AA, "R8", "data from close", cmd_data, 16'h00AA);

        // short low pulses
        addr = 18'h1555; wr_n = 0; tick(1); wr_n = 1; tick(6);
        addr = 18'h1555; wr_n = 0; tick(GW - 1); wr_n = 1; tick(6);
        expect_strobes(0, "R3");
        note(cmd_addr == 18'h2AAA, "R8", "address kept", cmd_addr, 18'h2AAA);

        wr_cycle(18'h0555, 16'h0055, 16'h0055, 6);
        expect_strobes(1, "R2");

        // high glitch inside an open cycle
        addr = 18'h0123; wdata = 16'hBEEF; wr_n = 0; tick(5);
        wr_n = 1; tick(GW - 1); wr_n = 0; tick(5); wr_n = 1; tick(8);
        expect_strobes(1, "R3");

        // chip-select controlled write
        cs_n = 1; tick(6);
        wr_n = 0; tick(6);
        expect_strobes(0, "R2");
        addr = 18'h3000; wdata = 16'hC0DE; cs_n = 0; tick(5); cs_n = 1; tick(8);
        expect_strobes(1, "R2");
        note(cmd_data == 16'hC0DE, "R8", "cs-controlled data", cmd_data, 16'hC0DE);
        wr_n = 1; cs_n = 0; tick(6);

        // read strobe low inhibits
        rd_n = 0; wr_n = 0; tick(6); wr_n = 1; tick(8);
        expect_strobes(0, "R2");
        rd_n = 1; tick(6);

        // read strobe low during an open cycle
        wr_n = 0; tick(6); rd_n = 0; tick(5); wr_n = 1; tick(5); rd_n = 1; tick(8);
        expect_strobes(0, "R4");

        // lockout mid-cycle, release with write strobe low
        wr_n = 0; tick(6);
        low_supply = 1; tick(6);
        note(hold_cmd == 1, "R5", "hold in lockout", hold_cmd, 1);
        wr_n = 1; tick(6); wr_n = 0; tick(6);
        low_supply = 0; tick(10);
        expect_strobes(0, "R5");
        note(hold_cmd == 0, "R10", "hold released", hold_cmd, 0);
        wr_n = 1; tick(10);
        expect_strobes(0, "R7");
        wr_cycle(18'h0AAA, 16'h00F0, 16'h00F0, 4);
        expect_strobes(1, "R7");

        // temporary unprotect
        hv_reset = 1; tick(3);
        @(negedge clk);
        note(unprot_active && eff_prot == '0, "R9", "unprotect zeros",
             eff_prot, 0);
        @(posedge clk); #2;
        sect_prot = 11'h7FF; tick(2);
        @(negedge clk);
        note(eff_prot == '0, "R9", "unprotect with new vector", eff_prot, 0);
        @(posedge clk); #2;
        low_supply = 1; tick(3);
        @(negedge clk);
        note(!unprot_active && eff_prot == 11'h7FF, "R9", "lockout drops unprotect",
             eff_prot, 11'h7FF);
        @(posedge clk); #2;
        low_supply = 0; tick(3);
        hv_reset = 0; sect_prot = 11'h30C; tick(3);
        @(negedge clk);
        note(eff_prot == 11'h30C, "R9", "protection restored", eff_prot, 11'h30C);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule